// File: doc/BRIEF.md
# SPI Register Bank with Address Sequencing

This block is the serial slave front end of a peripheral controller. A host reaches a 21-entry address space over a four-wire SPI link in mode 0. Every transaction, framed by chip select going low, begins with a command byte. The command byte picks a start address and a direction. Any number of data bytes then follow. Addresses 0 to 4 are data ports into external endpoint buffers. These are reached through one-cycle push and pop strobes. Addresses 5 to 20 are control and status registers held inside the block. Each of these registers has one of five access classes: plain read/write, 7-bit count, hardware-set flags cleared by writing ones, fixed constant, and live status mirror.

The SPI pins are oversampled by the system clock through a two-stage synchronizer. The controller is a five-state machine:
- `ST_IDLE`: chip select high.
- `ST_CMD`: waiting for the command byte.
- `ST_READ`: read burst.
- `ST_WRITE`: write burst.
- `ST_SKIP`: illegal address; bytes are swallowed.

Its transitions are:
- Any state goes to `ST_IDLE` when chip select rises.
- `ST_IDLE` goes to `ST_CMD` when chip select falls.
- `ST_CMD` goes to `ST_READ`, `ST_WRITE` or `ST_SKIP` when the command byte completes.
- `ST_READ`, `ST_WRITE` and `ST_SKIP` stay in place for each further byte.

A data port address stays fixed for the whole burst. A register address advances after every data byte and stops at 20.

Top module: `spi_regbank`

## Requirements
- R1: The command byte carries the address in bits 7:3 and the direction in bit 1 (1 = write, 0 = read). Bits 2 and 0 are ignored. The first bit on the wire is bit 7. MOSI is sampled on SCLK rising edges, MISO changes after falling edges, and MISO is 0 during the command byte.
- R2: For addresses 0 to 4, each written data byte gives one `fifo_push` cycle with `fifo_sel` equal to the address and `fifo_wdata` equal to the byte. Each read data byte returns the current `fifo_rdata` head and then gives one `fifo_pop` cycle. The address never changes within the burst.
- R3: For start addresses 5 to 19, each data byte read or written moves the address up by one.
- R4: The address stops at 20. Further bytes of the same transaction all access register 20.
- R5: Each transaction starts from its own command byte. Address state from an earlier transaction has no effect.
- R6: A command address of 21 to 31 is ignored for the whole transaction: no strobe, no register change, and MISO stays 0.
- R7: Register 18 always reads the constant `REV_CODE` (default 8'h2A). Register 19 always reads the live `sta_in` value. Writes to either have no effect.
- R8: Registers 11 and 13 are flags set by `evt_a` and `evt_b` respectively. Writing a 1 clears a bit and writing a 0 leaves it unchanged. A set in the same cycle as a clear leaves the bit at 1.
- R9: Registers 5 to 8 store bits 6:0 of a write, and bit 7 always reads 0.
- R10: Registers 9, 10, 12, 14, 15, 16, 17 and 20 store and return the full written byte.
- R11: If chip select rises in the middle of a byte, the partial byte is dropped: no register write and no strobe.
- R12: After reset, all registers 5 to 17 and 20 read 0, MISO is 0, and no strobe is active.
- R13: `fifo_push` and `fifo_pop` are never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI slave select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| fifo_sel | output | 3 | Data port index for the strobes and read data |
| fifo_push | output | 1 | One-cycle write strobe toward the selected port |
| fifo_wdata | output | 8 | Byte to push |
| fifo_pop | output | 1 | One-cycle read strobe toward the selected port |
| fifo_rdata | input | 8 | Head byte of the selected port |
| evt_a | input | 8 | Hardware set bits for flag register 11 |
| evt_b | input | 8 | Hardware set bits for flag register 13 |
| sta_in | input | 8 | Live status seen at register 19 |

## Verification
The two functions that can land in the same clock are a hardware flag set from `evt_a` and a host write-one-to-clear to register 11. The bench holds one `evt_a` bit high for the whole clearing transaction. This makes the set overlap the commit cycle whatever the synchronizer delay. The register is then read back: the held bit must still be 1 and every other bit must be 0. Sweeps over every register address and every data port check burst sequencing, saturation, and the rules for illegal addresses and aborted bytes at the pins.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int N_FIFO    = 5;
    localparam int SEL_W     = $clog2(N_FIFO);
    localparam int CSR_FIRST = N_FIFO;
    localparam int LAST_AT   = 20;
    localparam int CNT_LAST  = 8;
    localparam int FLAG_A_AT = 11;
    localparam int FLAG_B_AT = 13;
    localparam int REV_AT    = 18;
    localparam int STAT_AT   = 19;

    typedef enum logic [2:0] {
        ACC_RW,
        ACC_CNT,
        ACC_FLAG,
        ACC_CONST,
        ACC_MIRROR
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_WRITE,
        ST_SKIP
    } st_e;

    function automatic acc_e acc_of(input int a);
        if (a >= CSR_FIRST && a <= CNT_LAST) return ACC_CNT;
        if (a == FLAG_A_AT || a == FLAG_B_AT) return ACC_FLAG;
        if (a == REV_AT) return ACC_CONST;
        if (a == STAT_AT) return ACC_MIRROR;
        return ACC_RW;
    endfunction

    function automatic logic is_port(input logic [ADDR_W-1:0] a);
        return a < ADDR_W'(N_FIFO);
    endfunction

    // Data ports hold their address, registers advance and stop at the top.
    function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
        if (is_port(a)) return a;
        if (a >= ADDR_W'(LAST_AT)) return ADDR_W'(LAST_AT);
        return a + ADDR_W'(1);
    endfunction

endpackage

// File: rtl/spi_regbank_phy.sv
module spi_regbank_phy #(
    parameter int DW   = 8,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          cs_act,
    output logic          byte_done,
    output logic [DW-1:0] rx_byte,
    input  logic          tx_load,
    input  logic [DW-1:0] tx_data,
    output logic          miso
);
    localparam int CNT_W = $clog2(DW);

    logic [SYNC:0]   sclk_p;
    logic [SYNC-1:0] mosi_p;
    logic [SYNC-1:0] cs_p;
    logic            rise, fall, mosi_s;
    logic [CNT_W-1:0] bit_cnt;
    logic [DW-1:0]   rx_sh, tx_sh;
    logic            done_q, miso_q;

    assign rise   = sclk_p[SYNC-1] & ~sclk_p[SYNC];
    assign fall   = ~sclk_p[SYNC-1] & sclk_p[SYNC];
    assign mosi_s = mosi_p[SYNC-1];
    assign cs_act = ~cs_p[SYNC-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p <= '0;
            mosi_p <= '0;
            cs_p   <= '1;
        end else begin
            sclk_p <= {sclk_p[SYNC-1:0], sclk};
            mosi_p <= {mosi_p[SYNC-2:0], mosi};
            cs_p   <= {cs_p[SYNC-2:0], cs_n};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            done_q  <= 1'b0;
            miso_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
                rx_sh   <= '0;
                tx_sh   <= '0;
                miso_q  <= 1'b0;
            end else begin
                if (rise) begin
                    rx_sh   <= {rx_sh[DW-2:0], mosi_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == CNT_W'(DW - 1)) done_q <= 1'b1;
                end
                if (tx_load) begin
                    tx_sh <= tx_data;
                end else if (fall) begin
                    miso_q <= tx_sh[DW-1];
                    tx_sh  <= {tx_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign byte_done = done_q;
    assign rx_byte   = rx_sh;
    assign miso      = miso_q;

    // R11
    done_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (done_q -> $past(cs_act)));

endmodule

// File: rtl/spi_regbank_ctrl.sv
module spi_regbank_ctrl
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [ADDR_W-1:0] ptr,
    output logic              wr_en,
    output logic              push,
    output logic              pop,
    output logic              tx_load
);
    st_e               st_q, st_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              pend_q, pend_d;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_wr;

    assign cmd_addr = rx_byte[DATA_W-1 -: ADDR_W];
    assign cmd_wr   = rx_byte[1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ptr_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            ptr_q  <= ptr_d;
            pend_q <= pend_d;
        end
    end

    // Next state and address sequencing
    always_comb begin
        st_d   = st_q;
        ptr_d  = ptr_q;
        pend_d = 1'b0;
        if (!cs_act) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        if (cmd_addr > ADDR_W'(LAST_AT)) begin
                            st_d = ST_SKIP;
                        end else if (cmd_wr) begin
                            st_d  = ST_WRITE;
                            ptr_d = cmd_addr;
                        end else begin
                            st_d   = ST_READ;
                            ptr_d  = cmd_addr;
                            pend_d = 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (byte_done) begin
                        ptr_d  = addr_step(ptr_q);
                        pend_d = 1'b1;
                    end
                end
                ST_WRITE: begin
                    if (byte_done) ptr_d = addr_step(ptr_q);
                end
                ST_SKIP:  st_d = ST_SKIP;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en = 1'b0;
        push  = 1'b0;
        pop   = 1'b0;
        if (cs_act && byte_done) begin
            unique case (st_q)
                ST_WRITE: begin
                    if (is_port(ptr_q)) push = 1'b1;
                    else                wr_en = 1'b1;
                end
                ST_READ: begin
                    if (is_port(ptr_q)) pop = 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign ptr     = ptr_q;
    assign tx_load = pend_q;

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr_q >= ADDR_W'(CSR_FIRST) && ptr_q < ADDR_W'(LAST_AT))
        |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

    // R4
    ptr_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_READ || st_q == ST_WRITE) |-> ptr_q <= ADDR_W'(LAST_AT));

    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || push) |=> ptr_q == $past(ptr_q));

    // R13
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);

    // R13
    pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);

endmodule

// File: rtl/spi_regbank_regs.sv
module spi_regbank_regs
    import spi_regbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_CODE = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_a,
    input  logic [DATA_W-1:0] evt_b,
    input  logic [DATA_W-1:0] sta_in
);
    logic [DATA_W-1:0] q [CSR_FIRST:LAST_AT];

    for (genvar a = CSR_FIRST; a <= LAST_AT; a++) begin : g_reg
        if (acc_of(a) == ACC_CONST) begin : g_const
            assign q[a] = REV_CODE;
        end else if (acc_of(a) == ACC_MIRROR) begin : g_mirror
            assign q[a] = sta_in;
        end else if (acc_of(a) == ACC_FLAG) begin : g_flag
            logic              hit;
            logic [DATA_W-1:0] q_r, set_v, clr_v;
            assign hit = wr_en && (wr_addr == ADDR_W'(a));
            if (a == FLAG_A_AT) begin : g_src_a
                assign set_v = evt_a;
            end else begin : g_src_b
                assign set_v = evt_b;
            end
            assign clr_v = hit ? wr_data : '0;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_r <= '0;
                else        q_r <= (q_r & ~clr_v) | set_v;
            end
            assign q[a] = q_r;
        end else if (acc_of(a) == ACC_CNT) begin : g_cnt
            logic              hit;
            logic [DATA_W-2:0] q_r;
            assign hit = wr_en && (wr_addr == ADDR_W'(a));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q_r <= '0;
                else if (hit) q_r <= wr_data[DATA_W-2:0];
            end
            assign q[a] = {1'b0, q_r};
        end else begin : g_rw
            logic              hit;
            logic [DATA_W-1:0] q_r;
            assign hit = wr_en && (wr_addr == ADDR_W'(a));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q_r <= '0;
                else if (hit) q_r <= wr_data;
            end
            assign q[a] = q_r;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int a = CSR_FIRST; a <= LAST_AT; a++) begin
            if (rd_addr == ADDR_W'(a)) rd_data = q[a];
        end
    end

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_a != '0) |=> ((q[FLAG_A_AT] & $past(evt_a)) == $past(evt_a)));

    // R9
    cnt_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADDR_W'(CSR_FIRST) && rd_addr <= ADDR_W'(CNT_LAST)) |-> !rd_data[DATA_W-1]);

    // R7
    const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REV_AT)) |=> q[REV_AT] == REV_CODE);

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spi_regbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] REV_CODE = 8'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic [SEL_W-1:0]  fifo_sel,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_pop,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic [DATA_W-1:0] evt_a,
    input  logic [DATA_W-1:0] evt_b,
    input  logic [DATA_W-1:0] sta_in
);
    logic              cs_act, byte_done, tx_load, wr_en;
    logic [DATA_W-1:0] rx_byte, tx_data, reg_rdata;
    logic [ADDR_W-1:0] ptr;

    spi_regbank_phy #(.DW(DATA_W), .SYNC(2)) u_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .miso      (miso)
    );

    spi_regbank_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .push      (fifo_push),
        .pop       (fifo_pop),
        .tx_load   (tx_load)
    );

    spi_regbank_regs #(.REV_CODE(REV_CODE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (rx_byte),
        .rd_addr (ptr),
        .rd_data (reg_rdata),
        .evt_a   (evt_a),
        .evt_b   (evt_b),
        .sta_in  (sta_in)
    );

    assign tx_data    = is_port(ptr) ? fifo_rdata : reg_rdata;
    assign fifo_sel   = ptr[SEL_W-1:0];
    assign fifo_wdata = rx_byte;

endmodule

// File: tb/spi_regbank_tb.sv
module spi_regbank_tb;
    localparam int HALF = 8;
    localparam logic [7:0] REV = 8'h2A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, fifo_push, fifo_pop;
    logic [2:0] fifo_sel;
    logic [7:0] fifo_wdata, fifo_rdata;
    logic [7:0] evt_a = '0, evt_b = '0, sta_in = 8'h5C;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int pop_cnt [0:7];
    int push_n = 0, pulse_err = 0;
    logic [2:0] push_sel [0:63];
    logic [7:0] push_dat [0:63];
    logic push_prev = 0, pop_prev = 0;
    logic [7:0] tx_buf [0:31];
    logic [7:0] rx_buf [0:31];
    logic [7:0] mdl [5:20];

    always #10 clk = ~clk;

    spi_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .fifo_sel(fifo_sel), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
        .evt_a(evt_a), .evt_b(evt_b), .sta_in(sta_in)
    );

    // Endpoint buffer model: head byte is {port, pops so far}
    assign fifo_rdata = {fifo_sel, pop_cnt[fifo_sel][4:0]};

    initial for (int i = 0; i < 8; i++) pop_cnt[i] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_push) begin
                push_sel[push_n[5:0]] = fifo_sel;
                push_dat[push_n[5:0]] = fifo_wdata;
                push_n++;
            end
            if (fifo_pop) pop_cnt[fifo_sel]++;
            if ((fifo_push && push_prev) || (fifo_pop && pop_prev)) pulse_err++;
            push_prev = fifo_push;
            pop_prev  = fifo_pop;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_n(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cmd(input int a, input bit w, input bit junk);
        return {5'(a), junk, w, junk};
    endfunction

    function automatic string tag_of(input int a);
        if (a <= 8) return "R9";
        if (a == 11 || a == 13) return "R8";
        if (a == 18 || a == 19) return "R7";
        return "R10";
    endfunction

    function automatic logic [7:0] exp_of(input int a);
        if (a == 19) return sta_in;
        return mdl[a];
    endfunction

    function automatic void mdl_write(input int a, input logic [7:0] d);
        if (a <= 8) mdl[a] = {1'b0, d[6:0]};
        else if (a == 11 || a == 13) mdl[a] = mdl[a] & ~d;
        else if (a == 18 || a == 19) mdl[a] = mdl[a];
        else mdl[a] = d;
    endfunction

    task automatic spi_byte(input logic [7:0] o, output logic [7:0] r);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            repeat (HALF) @(negedge clk);
            r[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] c, input int n, output logic [7:0] cmd_rx);
        logic [7:0] r;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(c, cmd_rx);
        for (int i = 0; i < n; i++) begin
            spi_byte(tx_buf[i], r);
            rx_buf[i] = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    // One full data byte, then nbits of a second byte, then deselect
    task automatic xfer_abort(input logic [7:0] c, input int nbits);
        logic [7:0] r;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(c, r);
        spi_byte(tx_buf[0], r);
        for (int b = 0; b < nbits; b++) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic read_all(input string req);
        logic [7:0] c;
        for (int i = 0; i < 16; i++) tx_buf[i] = 8'h00;
        xfer(cmd(5, 0, 0), 16, c);
        for (int i = 0; i < 16; i++) chk({req, " ", tag_of(5 + i)}, rx_buf[i], exp_of(5 + i));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] c;
        int base, a, pn;
        for (int i = 5; i <= 20; i++) mdl[i] = 8'h00;
        mdl[18] = REV;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R12 reset state at the pins
        chk("R12 miso", {7'd0, miso}, 8'h00);
        chk("R12 strobes", {6'd0, fifo_push, fifo_pop}, 8'h00);

        // R12/R3/R4: burst read from 5 running past 20
        for (int i = 0; i < 18; i++) tx_buf[i] = 8'h00;
        xfer(cmd(5, 0, 0), 18, c);
        chk("R1 cmd byte miso", c, 8'h00);
        for (int i = 0; i < 18; i++) begin
            a = (5 + i > 20) ? 20 : 5 + i;
            chk(i < 16 ? "R12 R3" : "R4", rx_buf[i], exp_of(a));
        end

        // R3/R4: burst write with three extra bytes landing on 20
        for (int i = 0; i < 19; i++) tx_buf[i] = 8'((i * 37 + 11) ^ 8'h80);
        xfer(cmd(5, 1, 0), 19, c);
        for (int i = 0; i < 19; i++) mdl_write((5 + i > 20) ? 20 : 5 + i, tx_buf[i]);
        read_all("R3 R4");

        // R1/R7/R9/R10: single register sweep, ignored command bits set
        for (int r = 5; r <= 20; r++) begin
            tx_buf[0] = 8'((r * 73 + 29) | 8'h81);
            xfer(cmd(r, 1, 1), 1, c);
            mdl_write(r, tx_buf[0]);
            tx_buf[0] = 8'h00;
            xfer(cmd(r, 0, 1), 1, c);
            chk({"R1 ", tag_of(r)}, rx_buf[0], exp_of(r));
        end

        // R8 flags: set by events, write-one-to-clear
        @(negedge clk) evt_a = 8'hA5; evt_b = 8'h3C;
        @(negedge clk) evt_a = 8'h00; evt_b = 8'h00;
        mdl[11] = mdl[11] | 8'hA5;
        mdl[13] = mdl[13] | 8'h3C;
        tx_buf[0] = 8'h00;
        xfer(cmd(11, 0, 0), 3, c);
        chk("R8 set a", rx_buf[0], mdl[11]);
        chk("R8 set b", rx_buf[2], mdl[13]);
        tx_buf[0] = 8'h81;
        xfer(cmd(11, 1, 0), 1, c);
        mdl_write(11, 8'h81);
        tx_buf[0] = 8'h00;
        xfer(cmd(11, 1, 0), 1, c);
        xfer(cmd(11, 0, 0), 1, c);
        chk("R8 clear ones", rx_buf[0], 8'h24);
        tx_buf[0] = 8'h0C;
        xfer(cmd(13, 1, 0), 1, c);
        mdl_write(13, 8'h0C);
        tx_buf[0] = 8'h00;
        xfer(cmd(13, 0, 0), 1, c);
        chk("R8 clear b", rx_buf[0], 8'h30);

        // R8 set and clear in the same cycle: held event spans the commit
        @(negedge clk) evt_a = 8'h10;
        tx_buf[0] = 8'hFF;
        xfer(cmd(11, 1, 0), 1, c);
        @(negedge clk) evt_a = 8'h00;
        mdl[11] = 8'h10;
        tx_buf[0] = 8'h00;
        xfer(cmd(11, 0, 0), 1, c);
        chk("R8 set wins", rx_buf[0], 8'h10);

        // R2 data ports: fixed address bursts
        for (int p = 0; p < 5; p++) begin
            pn = push_n;
            for (int i = 0; i < 3; i++) tx_buf[i] = 8'(p * 40 + i * 7 + 1);
            xfer(cmd(p, 1, 0), 3, c);
            chk_n("R2 push count", push_n - pn, 3);
            for (int i = 0; i < 3; i++) begin
                chk("R2 push sel", {5'd0, push_sel[pn + i]}, 8'(p));
                chk("R2 push data", push_dat[pn + i], tx_buf[i]);
            end
            base = pop_cnt[p];
            for (int i = 0; i < 4; i++) tx_buf[i] = 8'h00;
            xfer(cmd(p, 0, 0), 4, c);
            for (int i = 0; i < 4; i++) chk("R2 pop data", rx_buf[i], {3'(p), 5'(base + i)});
            chk_n("R2 pop count", pop_cnt[p] - base, 4);
        end
        chk_n("R13 single cycle strobes", pulse_err, 0);

        // R6 illegal addresses
        for (int r = 21; r < 32; r++) begin
            pn = push_n;
            base = pop_cnt[0] + pop_cnt[1] + pop_cnt[2] + pop_cnt[3] + pop_cnt[4];
            tx_buf[0] = 8'hFF; tx_buf[1] = 8'hFF;
            xfer(cmd(r, 1, 0), 2, c);
            xfer(cmd(r, 0, 0), 2, c);
            chk("R6 miso zero", rx_buf[0] | rx_buf[1], 8'h00);
            chk_n("R6 no push", push_n - pn, 0);
            chk_n("R6 no pop", pop_cnt[0] + pop_cnt[1] + pop_cnt[2] + pop_cnt[3] + pop_cnt[4] - base, 0);
        end
        read_all("R6");

        // R5 new transaction sets a fresh address
        tx_buf[0] = 8'h6E; tx_buf[1] = 8'h91;
        xfer(cmd(14, 1, 0), 2, c);
        mdl_write(14, 8'h6E); mdl_write(15, 8'h91);
        tx_buf[0] = 8'h37;
        xfer(cmd(9, 1, 0), 1, c);
        mdl_write(9, 8'h37);
        for (int i = 0; i < 3; i++) tx_buf[i] = 8'h00;
        xfer(cmd(9, 0, 0), 3, c);
        chk("R5 first", rx_buf[0], mdl[9]);
        chk("R5 no carry", rx_buf[1], mdl[10]);
        xfer(cmd(14, 0, 0), 3, c);
        chk("R5 14", rx_buf[0], 8'h6E);
        chk("R5 15", rx_buf[1], 8'h91);
        chk("R5 16", rx_buf[2], mdl[16]);

        // R11 abort mid byte
        tx_buf[0] = 8'h5A;
        xfer_abort(cmd(16, 1, 0), 5);
        mdl_write(16, 8'h5A);
        tx_buf[0] = 8'h00;
        xfer(cmd(16, 0, 0), 2, c);
        chk("R11 full byte kept", rx_buf[0], 8'h5A);
        chk("R11 partial dropped", rx_buf[1], mdl[17]);
        pn = push_n;
        tx_buf[0] = 8'hC7;
        xfer_abort(cmd(2, 1, 0), 6);
        chk_n("R11 one push only", push_n - pn, 1);

        // R7 mirror follows the status input
        sta_in = 8'hC3;
        read_all("R7");
        chk_n("R13 single cycle strobes end", pulse_err, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule